// File: doc/BRIEF.md
# Multi-State Capture Trigger Sequencer

This block is the trigger state machine of a logic analyzer. Every clock it receives a vector of hit flags from the trigger sources (pattern matchers, range detectors, edge detectors and timer expiries). It evaluates three sums that belong to the current sequence state. The capture sum decides whether the current sample is stored. The match sum moves the sequence one state forward. The else sum sends it to a fallback state programmed for that state.

A match can also pulse a start command to either of two timers, whose expiry comes back later as a source. A state marked final turns its match into a one-cycle trigger pulse and holds the sequence in that state until it is disarmed or reset. While the arm input is low, software writes the per-state settings through a small address/data port and the sequence waits in state 0. Raising arm starts the evaluation from state 0.

Top module: `trig_sequencer`

## Requirements
- R1: After reset (rst_n low at a clock edge) state_o is 0, and capture_o, trig_o, done_o and tmr_start_o are all 0. Every setting is cleared to zero.
- R2: A sum is the OR of two terms. A term is true when its 16-bit mask is nonzero and every source selected by the mask is set in src_hit. capture_o shows the capture sum of the state that was current at the previous edge, one cycle after the sources are presented.
- R3: When armed and the match sum of the current state is true, state_o becomes the current state plus one at the next edge.
- R4: When armed and the else sum is true while the match sum is false, state_o becomes the target in bits [3:0] of the state's control word.
- R5: When the match sum and the else sum are both true in the same cycle, the match wins and the state advances by one.
- R6: A sum whose two masks are both zero is never true. A state with a zero match sum never advances, even with all sources set.
- R7: On a match, tmr_start_o[0] pulses for one cycle if control bit 8 is set, and tmr_start_o[1] pulses if control bit 9 is set. No start pulse is issued once done_o is high.
- R8: A match in a state whose control bit 10 is set gives a one-cycle trig_o pulse and raises done_o. The state then stays fixed and no further trigger, timer start or else jump happens, but capture_o keeps following that state's capture sum.
- R9: While arm is low, the state is 0 and all outputs are 0. Writes with cfg_we high take effect only while arm is low; writes made while armed are ignored. The address is {state[3:0], field[2:0]}, with fields 0/1 for the capture masks, 2/3 for the match masks, 4/5 for the else masks and 6 for the control word.
- R10: A match in the last state (15) that is not final leaves the state at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | High to run the sequence; low to idle in state 0 and allow writes |
| cfg_we | input | 1 | Setting write enable |
| cfg_addr | input | 7 | {state, field} write address |
| cfg_wdata | input | 16 | Write data: a mask or the control word |
| src_hit | input | 16 | Trigger source hit flags for this sample |
| capture_o | output | 1 | Store the sample presented on the previous cycle |
| trig_o | output | 1 | One-cycle final trigger pulse |
| tmr_start_o | output | 2 | Timer start pulses, bit 0 timer 1, bit 1 timer 2 |
| state_o | output | 4 | Current sequence state |
| done_o | output | 1 | Final trigger reached; sequence held |

## Verification
The bench aims at the points where a sequencer goes wrong. With match and else true together, a design with the wrong priority jumps to the target instead of advancing. A sum with zero masks must not pass: an AND over an empty set is true, so a naive design would advance on any input. After the final match, a design that keeps evaluating would fire trig_o again or keep moving the state. At state 15, an advance that wraps would return to state 0. Writes made while armed must leave the active settings unchanged, and random settings with random sources compare every cycle against a model of the sums and transitions.

// File: rtl/trig_seq_pkg.sv
// Shared constants for the trigger sequencer: field codes of the setting
// address and bit positions inside the per-state control word.
// Assumes at most 256 states, so the target fits in the low control byte.
package trig_seq_pkg;

    localparam int FLD_W        = 3;
    localparam int NUM_TERMS    = 2;
    localparam int CTRL_T1_BIT  = 8;
    localparam int CTRL_T2_BIT  = 9;
    localparam int CTRL_FIN_BIT = 10;

    typedef enum logic [FLD_W-1:0] {
        FLD_CAP_A  = 3'd0,
        FLD_CAP_B  = 3'd1,
        FLD_MAT_A  = 3'd2,
        FLD_MAT_B  = 3'd3,
        FLD_ELS_A  = 3'd4,
        FLD_ELS_B  = 3'd5,
        FLD_CTRL   = 3'd6,
        FLD_UNUSED = 3'd7
    } cfg_field_e;

endpackage

// File: rtl/trig_seq_cfg.sv
// Per-state setting storage. It holds six term masks, an else target,
// timer-start selects and a final flag for every state. Writes are gated
// outside this module; the read port is combinational on the state index.
module trig_seq_cfg
    import trig_seq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_ST  = 16,
    localparam int ST_W   = $clog2(NUM_ST)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ST_W-1:0]               wr_state,
    input  logic [FLD_W-1:0]              wr_field,
    input  logic [NUM_SRC-1:0]            wr_data,
    input  logic [ST_W-1:0]               rd_state,
    output logic [NUM_TERMS-1:0][NUM_SRC-1:0] cap_masks,
    output logic [NUM_TERMS-1:0][NUM_SRC-1:0] mat_masks,
    output logic [NUM_TERMS-1:0][NUM_SRC-1:0] els_masks,
    output logic [ST_W-1:0]               els_tgt,
    output logic [1:0]                    tmr_sel,
    output logic                          fin
);

    localparam int NUM_MASKS = 3 * NUM_TERMS;

    logic [NUM_SRC-1:0] mask_q [NUM_ST][NUM_MASKS];
    logic [ST_W-1:0]    tgt_q  [NUM_ST];
    logic [1:0]         tmr_q  [NUM_ST];
    logic               fin_q  [NUM_ST];

    logic state_ok;
    assign state_ok = int'(wr_state) < NUM_ST;

    // Storage update: clear on reset, otherwise load the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_ST; s++) begin
                for (int m = 0; m < NUM_MASKS; m++) mask_q[s][m] <= '0;
                tgt_q[s] <= '0;
                tmr_q[s] <= '0;
                fin_q[s] <= 1'b0;
            end
        end else if (wr_en && state_ok) begin
            if (int'(wr_field) < NUM_MASKS) begin
                mask_q[wr_state][int'(wr_field)] <= wr_data;
            end else if (wr_field == FLD_CTRL) begin
                tgt_q[wr_state] <= wr_data[ST_W-1:0];
                tmr_q[wr_state] <= {wr_data[CTRL_T2_BIT], wr_data[CTRL_T1_BIT]};
                fin_q[wr_state] <= wr_data[CTRL_FIN_BIT];
            end
        end
    end

    // Read port: present the settings of the current state.
    generate
        for (genvar t = 0; t < NUM_TERMS; t++) begin : g_rd
            assign cap_masks[t] = mask_q[rd_state][t];
            assign mat_masks[t] = mask_q[rd_state][NUM_TERMS + t];
            assign els_masks[t] = mask_q[rd_state][2*NUM_TERMS + t];
        end
    endgenerate

    assign els_tgt = tgt_q[rd_state];
    assign tmr_sel = tmr_q[rd_state];
    assign fin     = fin_q[rd_state];

endmodule

// File: rtl/trig_seq_sum.sv
// One trigger sum: an OR of AND terms over the source hit vector.
// A term with an all-zero mask is false, so zero masks encode "none".
module trig_seq_sum
    import trig_seq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_TERMS-1:0][NUM_SRC-1:0] masks,
    input  logic [NUM_SRC-1:0]                src,
    output logic                              hit
);

    logic [NUM_TERMS-1:0] term_hit;

    // Each term: mask nonzero and every selected source present.
    generate
        for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
            assign term_hit[t] = (|masks[t]) && ((src & masks[t]) == masks[t]);
        end
    endgenerate

    assign hit = |term_hit;

endmodule

// File: rtl/trig_seq_core.sv
// Sequence state register and registered outputs. Match has priority
// over else. A final match latches done and freezes the state until arm
// drops or reset. Assumes the sums refer to the state held in state_q.
module trig_seq_core #(
    parameter int NUM_ST = 16,
    localparam int ST_W  = $clog2(NUM_ST)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            cap_hit,
    input  logic            mat_hit,
    input  logic            els_hit,
    input  logic [ST_W-1:0] els_tgt,
    input  logic [1:0]      tmr_sel,
    input  logic            fin,
    output logic [ST_W-1:0] state_q,
    output logic            capture_q,
    output logic            trig_q,
    output logic [1:0]      tmr_q,
    output logic            done_q
);

    localparam logic [ST_W-1:0] LAST_ST = ST_W'(NUM_ST - 1);

    logic tgt_ok;
    assign tgt_ok = int'(els_tgt) < NUM_ST;

    // State transition and output pulses for one sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            state_q   <= '0;
            capture_q <= 1'b0;
            trig_q    <= 1'b0;
            tmr_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            capture_q <= cap_hit;
            trig_q    <= 1'b0;
            tmr_q     <= '0;
            if (!done_q) begin
                if (mat_hit) begin
                    tmr_q <= tmr_sel;
                    if (fin) begin
                        done_q <= 1'b1;
                        trig_q <= 1'b1;
                    end else if (state_q != LAST_ST) begin
                        state_q <= state_q + 1'b1;
                    end
                end else if (els_hit && tgt_ok) begin
                    state_q <= els_tgt;
                end
            end
        end
    end

endmodule

// File: rtl/trig_sequencer.sv
// Top of the trigger sequencer: setting bank, three sum evaluators and
// the state core. Setting writes are accepted only while arm is low.
module trig_sequencer
    import trig_seq_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_ST   = 16,
    localparam int ST_W    = $clog2(NUM_ST),
    localparam int ADDR_W  = ST_W + FLD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [NUM_SRC-1:0] cfg_wdata,
    input  logic [NUM_SRC-1:0] src_hit,
    output logic               capture_o,
    output logic               trig_o,
    output logic [1:0]         tmr_start_o,
    output logic [ST_W-1:0]    state_o,
    output logic               done_o
);

    logic [NUM_TERMS-1:0][NUM_SRC-1:0] cap_masks, mat_masks, els_masks;
    logic [ST_W-1:0] els_tgt;
    logic [1:0]      tmr_sel;
    logic            fin;
    logic            cap_hit, mat_hit, els_hit;

    trig_seq_cfg #(.NUM_SRC(NUM_SRC), .NUM_ST(NUM_ST)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && !arm),
        .wr_state (cfg_addr[ADDR_W-1:FLD_W]),
        .wr_field (cfg_addr[FLD_W-1:0]),
        .wr_data  (cfg_wdata),
        .rd_state (state_o),
        .cap_masks(cap_masks),
        .mat_masks(mat_masks),
        .els_masks(els_masks),
        .els_tgt  (els_tgt),
        .tmr_sel  (tmr_sel),
        .fin      (fin)
    );

    trig_seq_sum #(.NUM_SRC(NUM_SRC)) u_cap (.masks(cap_masks), .src(src_hit), .hit(cap_hit));
    trig_seq_sum #(.NUM_SRC(NUM_SRC)) u_mat (.masks(mat_masks), .src(src_hit), .hit(mat_hit));
    trig_seq_sum #(.NUM_SRC(NUM_SRC)) u_els (.masks(els_masks), .src(src_hit), .hit(els_hit));

    trig_seq_core #(.NUM_ST(NUM_ST)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .cap_hit  (cap_hit),
        .mat_hit  (mat_hit),
        .els_hit  (els_hit),
        .els_tgt  (els_tgt),
        .tmr_sel  (tmr_sel),
        .fin      (fin),
        .state_q  (state_o),
        .capture_q(capture_o),
        .trig_q   (trig_o),
        .tmr_q    (tmr_start_o),
        .done_q   (done_o)
    );

endmodule

// File: rtl/trig_sequencer_chk.sv
// Temporal checks on the sequencer ports, bound into every instance.
module trig_sequencer_chk #(
    parameter int ST_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arm,
    input logic            capture_o,
    input logic            trig_o,
    input logic [1:0]      tmr_start_o,
    input logic [ST_W-1:0] state_o,
    input logic            done_o
);

    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (state_o == '0 && !capture_o && !trig_o && tmr_start_o == 2'b00 && !done_o)); // R9

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R8

    AST_TRIG_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> done_o); // R8

    AST_DONE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && arm) |=> ($stable(state_o) && done_o)); // R8

    AST_NO_TMR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !trig_o) |-> tmr_start_o == 2'b00); // R7

endmodule

bind trig_sequencer trig_sequencer_chk #(.ST_W(ST_W)) u_chk (.*);

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;

    logic        clk = 1'b0;
    logic        rst_n, arm, cfg_we;
    logic [6:0]  cfg_addr;
    logic [15:0] cfg_wdata, src_hit;
    logic        capture_o, trig_o, done_o;
    logic [1:0]  tmr_start_o;
    logic [3:0]  state_o;

    always #4 clk = ~clk;

    trig_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_hit(src_hit), .capture_o(capture_o), .trig_o(trig_o),
        .tmr_start_o(tmr_start_o), .state_o(state_o), .done_o(done_o)
    );

    int n_run = 0, n_fail = 0;
    logic [15:0] m_cfg [16][8];
    logic [3:0]  e_state;
    logic        e_cap, e_trig, e_done;
    logic [1:0]  e_tmr;

    function automatic logic sum_hit(logic [15:0] a, logic [15:0] b, logic [15:0] s);
        return ((a != 0) && ((s & a) == a)) || ((b != 0) && ((s & b) == b));
    endfunction

    function automatic logic [15:0] ctrl(logic [3:0] tgt, logic t1, logic t2, logic fin);
        return {5'b0, fin, t2, t1, 4'b0, tgt};
    endfunction

    // One cycle: drive sources, advance the model, compare at the next negedge.
    task automatic cyc(input logic [15:0] s, input string tag);
        logic [3:0] st;
        logic m, e;
        src_hit = s;
        if (!arm) begin
            e_state = 0; e_cap = 0; e_trig = 0; e_tmr = 0; e_done = 0;
        end else begin
            st = e_state;
            e_cap  = sum_hit(m_cfg[st][0], m_cfg[st][1], s);
            m      = sum_hit(m_cfg[st][2], m_cfg[st][3], s);
            e      = sum_hit(m_cfg[st][4], m_cfg[st][5], s);
            e_trig = 0; e_tmr = 0;
            if (!e_done) begin
                if (m) begin
                    e_tmr = {m_cfg[st][6][9], m_cfg[st][6][8]};
                    if (m_cfg[st][6][10]) begin e_done = 1; e_trig = 1; end
                    else if (st != 4'd15) e_state = st + 1;
                end else if (e) e_state = m_cfg[st][6][3:0];
            end
        end
        if (cfg_we && !arm) m_cfg[cfg_addr[6:3]][cfg_addr[2:0]] = cfg_wdata;
        @(negedge clk);
        n_run++;
        if (state_o !== e_state || capture_o !== e_cap || trig_o !== e_trig ||
            tmr_start_o !== e_tmr || done_o !== e_done) begin
            n_fail++;
            $display("FAIL %s: actual st=%0d cap=%0b trig=%0b tmr=%0b done=%0b expected st=%0d cap=%0b trig=%0b tmr=%0b done=%0b",
                tag, state_o, capture_o, trig_o, tmr_start_o, done_o,
                e_state, e_cap, e_trig, e_tmr, e_done);
        end
    endtask

    task automatic wr(input int st, input int fld, input logic [15:0] d);
        cfg_we = 1; cfg_addr = {st[3:0], fld[2:0]}; cfg_wdata = d;
        cyc(16'h0, "R9");
        cfg_we = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; arm = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; src_hit = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int s = 0; s < 16; s++) for (int f = 0; f < 8; f++) m_cfg[s][f] = 16'h0;
        e_state = 0; e_cap = 0; e_trig = 0; e_tmr = 0; e_done = 0;
    endtask

    function automatic logic [15:0] rnd_mask();
        logic [15:0] m = 16'h0;
        if ($urandom_range(0, 5) == 0) return 16'h0;
        m[$urandom_range(0, 15)] = 1'b1;
        if ($urandom_range(0, 1) == 1) m[$urandom_range(0, 15)] = 1'b1;
        return m;
    endfunction

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        do_reset();
        cyc(16'h0, "R1");                      // R1 reset state
        cyc(16'hFFFF, "R1");

        // R2/R3: two AND terms ORed, match advances by one
        wr(0, 2, 16'h0003); wr(0, 3, 16'h0004); wr(1, 2, 16'h0008); wr(0, 0, 16'h0001);
        arm = 1;
        cyc(16'h0001, "R2");                   // partial term: capture only
        cyc(16'h0003, "R3");                   // full term A: advance to 1
        cyc(16'h0004, "R2");                   // state 1 needs bit 3
        cyc(16'h0008, "R3");                   // to state 2

        // R4/R5: else jump and match priority
        do_reset();
        wr(0, 2, 16'h0001); wr(0, 4, 16'h0002); wr(0, 6, ctrl(4'd5, 0, 0, 0));
        wr(5, 4, 16'h0010); wr(5, 6, ctrl(4'd0, 0, 0, 0));
        arm = 1;
        cyc(16'h0002, "R4");                   // jump to 5
        cyc(16'h0010, "R4");                   // back to 0
        cyc(16'h0003, "R5");                   // both true: advance to 1

        // R6: zero match masks never advance
        do_reset();
        wr(0, 4, 16'h0020); wr(0, 6, ctrl(4'd3, 0, 0, 0));
        arm = 1;
        cyc(16'hFFDF, "R6");                   // nothing at all
        cyc(16'hFFFF, "R6");                   // else only: to 3
        cyc(16'hFFFF, "R6");                   // state 3 has no sums

        // R7/R8: timer starts and final trigger
        do_reset();
        wr(0, 2, 16'h0001); wr(0, 6, ctrl(4'd0, 1, 0, 0));
        wr(1, 2, 16'h0002); wr(1, 4, 16'h0004); wr(1, 0, 16'h0010);
        wr(1, 6, ctrl(4'd0, 0, 1, 1));
        arm = 1;
        cyc(16'h0001, "R7");                   // timer 1 start
        cyc(16'h0006, "R8");                   // final: trig, timer 2
        cyc(16'h0016, "R8");                   // held, capture continues
        cyc(16'h0006, "R8");
        arm = 0;
        cyc(16'h0000, "R9");                   // disarm clears done

        // R10: last state holds on match
        do_reset();
        wr(0, 4, 16'h0002); wr(0, 6, ctrl(4'd15, 0, 0, 0)); wr(15, 2, 16'h0001);
        arm = 1;
        cyc(16'h0002, "R10");
        cyc(16'h0001, "R10");

        // R9: writes while armed are ignored
        do_reset();
        arm = 1;
        cfg_we = 1; cfg_addr = {4'd0, 3'd2}; cfg_wdata = 16'h0001;
        cyc(16'h0000, "R9");
        cfg_we = 0;
        cyc(16'h0001, "R9");                   // still no match sum
        arm = 0;
        cyc(16'h0001, "R9");

        // Random settings and sources, R2 R3 R4 R5 checked per cycle
        for (int rep = 0; rep < 6; rep++) begin
            do_reset();
            for (int s = 0; s < 16; s++) begin
                for (int f = 0; f < 6; f++) wr(s, f, rnd_mask());
                wr(s, 6, ctrl(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                              1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0)));
            end
            arm = 1;
            for (int c = 0; c < 400; c++) begin
                if ($urandom_range(0, 99) == 0) arm = 0;
                else arm = 1;
                cyc(16'($urandom), "R2 R3 R4 R5");
            end
            arm = 0;
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule